// File: doc/BRIEF.md
# Prioritized Interrupt Vectoring Unit

This block decides, at every instruction boundary, whether the processor should divert into an interrupt handler and, if so, which one. Six request sources feed it. Five are event flags that the unit latches internally and clears when their interrupt is acknowledged: timer 3, timer 4, keyboard, uplink and downlink. The sixth is a level: a vector of hardware error status bits that requests service for as long as any bit is set.

When an interrupt is taken, the unit emits a one-cycle take pulse with the vector address of the winning source. It saves the program counter and the pending instruction word into two holding registers, enters a single-level "in service" state, and reports the extra machine cycles the diversion costs.

The unit also decodes three special operations carried in the instruction word: interrupt enable, interrupt disable and return-from-interrupt. A return pulses a resume strobe, leaves the saved program counter and instruction on the holding outputs so the sequencer can restore them, and leaves the in-service state. A return issued outside a handler only raises an error pulse. The handler's own execution is outside this block.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the take, resume and error pulses are low, the vector, holding registers and extra-cycle count are zero, and the inhibit and in-service states are clear.
- R2: Among pending sources the winner is, highest first: timer 3 (vector octal 2000), error (2004), timer 4 (2010), keyboard (2014), uplink (2020), downlink (2024). The vector appears one clock after the boundary strobe, together with a single-cycle take pulse.
- R3: No interrupt is taken while inhibit is set, while in service, while the two accumulator top bits are 01 or 10, or while the extracode input is high.
- R4: The error source is requested while any bit of the error status input is nonzero. It is never cleared by acknowledgement, so it wins again after a return if still set.
- R5: Only the winning source is acknowledged per boundary. A latched flag is cleared only when its own interrupt is taken, and other pending flags stay pending.
- R6: Taking an interrupt loads the Z-save output with the program counter and the B-save output with the instruction word, sets in-service, and reports 3 extra cycles.
- R7: The instruction is treated as a special operation when extracode is low and instruction bits 14:12 equal 2. Operand octal 016 (bits 11:0) clears inhibit, and operand 017 sets it. Either takes effect only at a boundary where no interrupt is taken.
- R8: Operand octal 025 while in service pulses resume, clears in-service, reports 2 extra cycles, and leaves Z-save and B-save unchanged.
- R9: Operand octal 025 while not in service pulses the error output and changes no other state.
- R10: Without a boundary strobe no interrupt is taken and no special operation acts. The vector reads zero in every cycle without a take pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary | input | 1 | Instruction boundary strobe |
| t3_set | input | 1 | Timer 3 overflow event |
| t4_set | input | 1 | Timer 4 overflow event |
| key_set | input | 1 | Keystroke event |
| up_set | input | 1 | Uplink word ready event |
| dn_set | input | 1 | Downlink ready event |
| err_status | input | EW | Error status bits, level request when nonzero |
| acc_top | input | 2 | Top two accumulator bits |
| extracode | input | 1 | Current instruction is an extracode |
| pc | input | AW | Program counter at the boundary |
| instr | input | WW | Pending instruction word |
| take | output | 1 | Interrupt taken pulse |
| vector | output | AW | Handler address, valid with take |
| zsave | output | AW | Saved program counter |
| bsave | output | WW | Saved instruction word |
| in_service | output | 1 | Handler active state |
| inhibit | output | 1 | Interrupt inhibit state |
| resume | output | 1 | Return-from-interrupt pulse |
| resume_err | output | 1 | Return issued outside a handler |
| extra_cyc | output | 2 | Extra machine cycles charged |

## Verification
The embedded assertions watch, on every cycle, that take, resume and the error pulse never coincide, that take never repeats in consecutive cycles, that a take only follows a cycle where inhibit and in-service were clear, and that the vector is zero outside a take. They also check that a take always leaves the unit in service and that a resume always leaves it out of service. The priority ordering, the level behaviour of the error source, the one-acknowledge-per-boundary rule, the accumulator and extracode blocking, and the inhibit operations can only be shown by the bench's scenarios. Those scenarios stack several requests and then walk through take and return pairs.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int AW = 12,
  parameter int WW = 16,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          t3_set,
  input  logic          t4_set,
  input  logic          key_set,
  input  logic          up_set,
  input  logic          dn_set,
  input  logic [EW-1:0] err_status,
  input  logic [1:0]    acc_top,
  input  logic          extracode,
  input  logic [AW-1:0] pc,
  input  logic [WW-1:0] instr,
  output logic          take,
  output logic [AW-1:0] vector,
  output logic [AW-1:0] zsave,
  output logic [WW-1:0] bsave,
  output logic          in_service,
  output logic          inhibit,
  output logic          resume,
  output logic          resume_err,
  output logic [1:0]    extra_cyc
);
  localparam int NSRC = 6;
  localparam logic [AW-1:0] VBASE = AW'(12'o2000);
  localparam logic [2:0]  OP_SPECIAL = 3'd2;
  localparam logic [11:0] OPD_ENABLE = 12'o016;
  localparam logic [11:0] OPD_DISABLE = 12'o017;
  localparam logic [11:0] OPD_RESUME = 12'o025;

  logic t3_q, t4_q, key_q, up_q, dn_q;
  logic [NSRC-1:0] req, ack;
  logic [AW-1:0] vec_next;
  logic gate, do_take, special;

  assign req = {dn_q, up_q, key_q, t4_q, |err_status, t3_q};
  assign ack = req & (~req + 1'b1);
  assign gate = !inhibit && !in_service && !(acc_top == 2'b01 || acc_top == 2'b10) && !extracode;
  assign do_take = boundary && gate && |req;
  assign special = boundary && !do_take && !extracode && instr[14:12] == OP_SPECIAL;

  always_comb begin
    vec_next = VBASE;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req[i]) vec_next = VBASE + AW'(4 * i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {t3_q, t4_q, key_q, up_q, dn_q} <= '0;
      take <= 1'b0;
      vector <= '0;
      zsave <= '0;
      bsave <= '0;
      in_service <= 1'b0;
      inhibit <= 1'b0;
      resume <= 1'b0;
      resume_err <= 1'b0;
      extra_cyc <= '0;
    end else begin
      t3_q  <= (t3_q  && !(do_take && ack[0])) || t3_set;
      t4_q  <= (t4_q  && !(do_take && ack[2])) || t4_set;
      key_q <= (key_q && !(do_take && ack[3])) || key_set;
      up_q  <= (up_q  && !(do_take && ack[4])) || up_set;
      dn_q  <= (dn_q  && !(do_take && ack[5])) || dn_set;
      take <= do_take;
      vector <= do_take ? vec_next : '0;
      resume <= 1'b0;
      resume_err <= 1'b0;
      extra_cyc <= do_take ? 2'd3 : 2'd0;
      if (do_take) begin
        zsave <= pc;
        bsave <= instr;
        in_service <= 1'b1;
      end
      if (special) begin
        case (instr[11:0])
          OPD_ENABLE:  inhibit <= 1'b0;
          OPD_DISABLE: inhibit <= 1'b1;
          OPD_RESUME: begin
            if (in_service) begin
              in_service <= 1'b0;
              resume <= 1'b1;
              extra_cyc <= 2'd2;
            end else begin
              resume_err <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_single_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take, resume, resume_err}));
  assert_take_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  assert_vector_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> vector == '0);
  assert_take_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !$past(inhibit) && !$past(in_service));
  assert_take_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> in_service && extra_cyc == 2'd3);
  assert_resume_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> !in_service && $past(in_service) && $stable(zsave));
endmodule

// File: tb/irq_vector_unit_bench.sv
`timescale 1ns/1ps
module irq_vector_unit_bench;
  localparam int AW = 12, WW = 16, EW = 8;
  localparam logic [WW-1:0] I_PLAIN = 16'o060100;
  localparam logic [WW-1:0] I_EN = 16'o020016;
  localparam logic [WW-1:0] I_DIS = 16'o020017;
  localparam logic [WW-1:0] I_RES = 16'o020025;

  logic clk = 0, rst_n = 0, boundary = 0;
  logic t3_set = 0, t4_set = 0, key_set = 0, up_set = 0, dn_set = 0;
  logic [EW-1:0] err_status = '0;
  logic [1:0] acc_top = 2'b00;
  logic extracode = 0;
  logic [AW-1:0] pc = '0;
  logic [WW-1:0] instr = '0;
  logic take, in_service, inhibit, resume, resume_err;
  logic [AW-1:0] vector, zsave;
  logic [WW-1:0] bsave;
  logic [1:0] extra_cyc;

  irq_vector_unit u_irq_vector_unit (.*);

  always #4 clk = ~clk;

  typedef struct {
    string tag;
    logic tk; logic [AW-1:0] vec; logic [AW-1:0] zs; logic [WW-1:0] bs;
    logic insvc; logic inh; logic res; logic rerr; logic [1:0] ex;
  } item_t;

  item_t q[$];
  int runs = 0, fails = 0;
  logic [AW-1:0] exp_zs = '0;
  logic [WW-1:0] exp_bs = '0;
  logic exp_insvc = 0, exp_inh = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0o expected=%0o", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      chk(e.tag, "take", 32'(take), 32'(e.tk));
      chk(e.tag, "vector", 32'(vector), 32'(e.vec));
      chk(e.tag, "zsave", 32'(zsave), 32'(e.zs));
      chk(e.tag, "bsave", 32'(bsave), 32'(e.bs));
      chk(e.tag, "in_service", 32'(in_service), 32'(e.insvc));
      chk(e.tag, "inhibit", 32'(inhibit), 32'(e.inh));
      chk(e.tag, "resume", 32'(resume), 32'(e.res));
      chk(e.tag, "resume_err", 32'(resume_err), 32'(e.rerr));
      chk(e.tag, "extra_cyc", 32'(extra_cyc), 32'(e.ex));
    end
  end

  task automatic drive(string tag, logic bnd, logic [WW-1:0] ins, logic [AW-1:0] p,
                       logic [1:0] acc, logic ext, item_t e);
    @(negedge clk); #1;
    boundary = bnd; instr = ins; pc = p; acc_top = acc; extracode = ext;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk); #1;
    boundary = 0; acc_top = 2'b00; extracode = 0;
  endtask

  function automatic item_t base();
    item_t e;
    e.tag = ""; e.tk = 0; e.vec = '0; e.zs = exp_zs; e.bs = exp_bs;
    e.insvc = exp_insvc; e.inh = exp_inh; e.res = 0; e.rerr = 0; e.ex = 0;
    return e;
  endfunction

  task automatic expect_take(string tag, logic [AW-1:0] p, logic [WW-1:0] ins,
                             logic [AW-1:0] v, logic [1:0] acc = 2'b00);
    item_t e;
    exp_zs = p; exp_bs = ins; exp_insvc = 1;
    e = base(); e.tk = 1; e.vec = v; e.ex = 3;
    drive(tag, 1, ins, p, acc, 0, e);
  endtask

  task automatic expect_none(string tag, logic bnd, logic [WW-1:0] ins,
                             logic [1:0] acc = 2'b00, logic ext = 0);
    drive(tag, bnd, ins, 12'o0777, acc, ext, base());
  endtask

  task automatic do_resume(string tag);
    item_t e;
    exp_insvc = 0;
    e = base(); e.res = 1; e.ex = 2;
    drive(tag, 1, I_RES, 12'o0500, 2'b00, 0, e);
  endtask

  task automatic pulse(logic a3, logic a4, logic ak, logic au, logic ad);
    @(negedge clk); #1;
    t3_set = a3; t4_set = a4; key_set = ak; up_set = au; dn_set = ad;
    @(negedge clk); #1;
    {t3_set, t4_set, key_set, up_set, dn_set} = '0;
  endtask

  initial begin
    begin : watchdog
      #1600000;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    item_t e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_none("R1 reset", 0, I_PLAIN);
    pulse(1, 1, 1, 1, 1);
    err_status = 8'h01;
    expect_take("R2 R6 timer3 first", 12'o0100, I_PLAIN, 12'o2000);
    expect_none("R3 in service blocks", 1, I_PLAIN);
    do_resume("R8 resume");
    expect_take("R4 R5 error level wins", 12'o0101, 16'o070011, 12'o2004);
    do_resume("R8 resume2");
    err_status = '0;
    expect_take("R2 timer4", 12'o0102, I_PLAIN, 12'o2010);
    do_resume("R8 resume3");
    expect_take("R2 keyboard", 12'o0103, I_PLAIN, 12'o2014);
    do_resume("R8 resume4");
    expect_take("R2 uplink", 12'o0104, I_PLAIN, 12'o2020);
    do_resume("R8 resume5");
    expect_take("R2 R5 downlink", 12'o0105, I_PLAIN, 12'o2024);
    do_resume("R8 resume6");
    expect_none("R5 all acknowledged", 1, I_PLAIN);
    e = base(); e.rerr = 1;
    drive("R9 stray resume", 1, I_RES, 12'o0200, 2'b00, 0, e);
    exp_inh = 1;
    expect_none("R7 disable", 1, I_DIS);
    pulse(1, 0, 0, 0, 0);
    expect_none("R3 R7 inhibited", 1, I_PLAIN);
    exp_inh = 0;
    expect_none("R7 enable", 1, I_EN);
    expect_take("R7 take after enable", 12'o0300, I_PLAIN, 12'o2000);
    do_resume("R8 resume7");
    pulse(1, 0, 0, 0, 0);
    expect_none("R3 acc 01", 1, I_PLAIN, 2'b01);
    expect_none("R3 acc 10", 1, I_PLAIN, 2'b10);
    expect_none("R3 extracode", 1, I_PLAIN, 2'b00, 1);
    expect_none("R7 extracode not special", 1, I_DIS, 2'b00, 1);
    expect_take("R3 acc 11 allowed", 12'o0400, I_PLAIN, 12'o2000, 2'b11);
    do_resume("R8 resume8");
    pulse(0, 1, 0, 0, 0);
    expect_none("R10 no boundary", 0, I_PLAIN);
    expect_none("R10 no boundary special", 0, I_DIS);
    expect_take("R10 pending kept", 12'o0401, I_PLAIN, 12'o2010);
    do_resume("R8 resume9");
    @(negedge clk); @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule